// File: doc/BRIEF.md
# Multi-Mode Buzzer Tone Generator

This block drives a piezo buzzer pin with a square-wave tone. One of eight pitches is chosen by a 3-bit select. One of four envelopes gates the tone: steady, a single timed burst per trigger, a 10 Hz on/off chop, or the same chop confined to the first half of every second. Whenever the tone is gated off or the block is disabled, the pin is held low.

Timing derives from the system clock through a prescaler that produces a base tick of 60 kHz. `TICK_DIV` is the number of system clocks per tick. Every pitch is a whole number of ticks per half period. The envelope counts ticks in 50 ms segments of `SEG_TICKS` ticks each (3000 at 60 kHz). Each burst and chop phase is a whole number of segments. A new enable, pitch, mode or trigger restarts the matching counter, so the output pattern always starts from a known point.

Top module: `buzz_tone_gen`

## Requirements
- R1: While `rst_n` is low at a clock edge, every counter clears, and `buzz_o` is low after that edge.
- R2: A base tick occurs once every `TICK_DIV` clocks. The first tick is at the `TICK_DIV`-th clock edge after reset is released. All tone and envelope timing advances only on ticks.
- R3: `freq_sel_i` values 0 to 7 select 0.625, 0.75, 1.0, 1.25, 1.5, 2.0, 2.5 and 3.0 kHz. These are half periods of 48, 40, 30, 24, 20, 15, 12 and 10 ticks.
- R4: The tone restarts low on the edge where the block becomes enabled or `freq_sel_i` changes. It then toggles after every full half period of ticks.
- R5: When `en_i` is low at an edge, `buzz_o` is low after that edge, and the tone and envelope restart.
- R6: `mode_i` = 0 (continuous): `buzz_o` follows the tone for as long as the block is enabled.
- R7: `mode_i` = 1 (single): a high `trig_i` starts a burst of two segments (100 ms), during which the tone passes. A trigger during a burst restarts the burst from its beginning. Outside a burst, the output is low.
- R8: `mode_i` = 2 (chop): the tone passes during even-numbered segments and is blocked during odd ones. This gives 50 ms on and 50 ms off.
- R9: `mode_i` = 3 (pulsed chop): segments are numbered 0 to 19, repeating every second. The chop pattern of R8 applies in segments 0 to 9, and the output is silent in segments 10 to 19.
- R10: A change of `mode_i` while enabled restarts the envelope at segment 0, with no burst active.
- R11: `trig_i` has no effect in modes other than single.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| en_i | input | 1 | Buzzer enable |
| mode_i | input | 2 | Envelope mode: 0 continuous, 1 single, 2 chop, 3 pulsed chop |
| freq_sel_i | input | 3 | Pitch select, 0 lowest to 7 highest |
| trig_i | input | 1 | Burst trigger, used in single mode |
| buzz_o | output | 1 | Buzzer drive pin |

## Verification
The embedded properties check the following on every cycle:
- the tick never arrives on two clocks in a row;
- the tone phase only moves on a tick;
- a disable silences the pin on the next edge;
- a trigger in single mode arms a fresh burst;
- a mode change zeroes the envelope.

Exact pitch lengths, burst lengths, retrigger extension, the 50 ms chop and the silent half-second emerge only over thousands of cycles. The bench shows these by comparing the pin every cycle against a tick-level model built from elapsed-time arithmetic. That comparison runs through directed pitch sweeps, burst and retrigger sequences, ignored triggers, and randomized mode and pitch changes.

// File: rtl/buzz_pkg.sv
// Package: shared types and constants for the buzzer tone generator.
// Assumes a 60 kHz base tick; pitches are whole half-period tick counts.
package buzz_pkg;

    typedef enum logic [1:0] {
        BZ_CONT   = 2'd0,
        BZ_SINGLE = 2'd1,
        BZ_CHOP   = 2'd2,
        BZ_PULSE  = 2'd3
    } bz_mode_e;

    localparam int HALF_W        = 6;   // holds the largest half period (48)
    localparam int SEGS_PER_SEC  = 20;  // 50 ms segments in one second
    localparam int BURST_SEGS    = 2;   // single burst length in segments
    localparam int PULSE_ON_SEGS = 10;  // segments of chop per second in pulsed mode
    localparam int SEG_IDX_W     = $clog2(SEGS_PER_SEC);

    // Half period in base ticks for each pitch select (60 kHz / (2 * f)).
    function automatic logic [HALF_W-1:0] half_ticks(input logic [2:0] sel);
        logic [HALF_W-1:0] h;
        case (sel)
            3'd0:    h = 6'd48;
            3'd1:    h = 6'd40;
            3'd2:    h = 6'd30;
            3'd3:    h = 6'd24;
            3'd4:    h = 6'd20;
            3'd5:    h = 6'd15;
            3'd6:    h = 6'd12;
            default: h = 6'd10;
        endcase
        return h;
    endfunction

endpackage

// File: rtl/buzz_tick_div.sv
// Module: prescaler producing a one-clock base tick every TICK_DIV clocks.
// Assumes TICK_DIV >= 1; with TICK_DIV == 1 the tick is always high.
module buzz_tick_div #(
    parameter int TICK_DIV = 1000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);

    generate
        if (TICK_DIV == 1) begin : g_direct
            assign tick_o = 1'b1;
        end else begin : g_count
            localparam int CW = $clog2(TICK_DIV);
            logic [CW-1:0] cnt_q;

            // Count clocks and wrap at the divider limit.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cnt_q <= '0;
                end else if (cnt_q == CW'(TICK_DIV - 1)) begin
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end

            assign tick_o = (cnt_q == CW'(TICK_DIV - 1));

            AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
                tick_o |=> !tick_o); // R2
        end
    endgenerate

endmodule

// File: rtl/buzz_tone_osc.sv
// Module: square-wave oscillator built from a half-period tick counter.
// Assumes tick_i is a one-clock pulse; restarts low on disable or pitch change.
module buzz_tone_osc
    import buzz_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic       en_i,
    input  logic [2:0] freq_sel_i,
    output logic       phase_o
);

    logic [2:0]        sel_q;
    logic [HALF_W-1:0] cnt_q;
    logic [HALF_W-1:0] half_last;
    logic              restart;

    assign half_last = half_ticks(freq_sel_i) - HALF_W'(1);
    assign restart   = !en_i || (freq_sel_i != sel_q);

    // Advance the half-period count on ticks and flip the phase at its end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q   <= '0;
            cnt_q   <= '0;
            phase_o <= 1'b0;
        end else begin
            sel_q <= freq_sel_i;
            if (restart) begin
                cnt_q   <= '0;
                phase_o <= 1'b0;
            end else if (tick_i) begin
                if (cnt_q == half_last) begin
                    cnt_q   <= '0;
                    phase_o <= ~phase_o;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    AST_TONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && freq_sel_i == sel_q && !tick_i) |=> $stable(phase_o)); // R4

    AST_TONE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !phase_o); // R5

endmodule

// File: rtl/buzz_envelope.sv
// Module: envelope gate for continuous, single, chop and pulsed-chop modes.
// Assumes SEG_TICKS >= 2 ticks per 50 ms segment; mode change restarts timing.
module buzz_envelope
    import buzz_pkg::*;
#(
    parameter int SEG_TICKS = 3000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic       en_i,
    input  logic [1:0] mode_i,
    input  logic       trig_i,
    output logic       gate_o
);

    localparam int SCW = $clog2(SEG_TICKS);

    bz_mode_e             mode_q;
    bz_mode_e             mode_in;
    logic [SCW-1:0]       seg_cnt_q;
    logic [SEG_IDX_W-1:0] seg_idx_q;
    logic                 burst_q;
    logic                 restart;
    logic                 seg_end;

    assign mode_in = bz_mode_e'(mode_i);
    assign restart = !en_i || (mode_in != mode_q);
    assign seg_end = (seg_cnt_q == SCW'(SEG_TICKS - 1));

    // Track segment position within the second and the single-burst flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q    <= BZ_CONT;
            seg_cnt_q <= '0;
            seg_idx_q <= '0;
            burst_q   <= 1'b0;
        end else begin
            mode_q <= mode_in;
            if (restart) begin
                seg_cnt_q <= '0;
                seg_idx_q <= '0;
                burst_q   <= 1'b0;
            end else if (mode_in == BZ_SINGLE && trig_i) begin
                seg_cnt_q <= '0;
                seg_idx_q <= '0;
                burst_q   <= 1'b1;
            end else if (tick_i) begin
                if (seg_end) begin
                    seg_cnt_q <= '0;
                    seg_idx_q <= (seg_idx_q == SEG_IDX_W'(SEGS_PER_SEC - 1))
                                 ? '0 : seg_idx_q + 1'b1;
                    if (seg_idx_q == SEG_IDX_W'(BURST_SEGS - 1)) begin
                        burst_q <= 1'b0;
                    end
                end else begin
                    seg_cnt_q <= seg_cnt_q + 1'b1;
                end
            end
        end
    end

    // Decode the gate from the registered mode and segment position.
    always_comb begin
        case (mode_q)
            BZ_CONT:   gate_o = 1'b1;
            BZ_SINGLE: gate_o = burst_q;
            BZ_CHOP:   gate_o = !seg_idx_q[0];
            default:   gate_o = !seg_idx_q[0] &&
                                (seg_idx_q < SEG_IDX_W'(PULSE_ON_SEGS));
        endcase
    end

    AST_BURST_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && mode_in == BZ_SINGLE && mode_q == BZ_SINGLE && trig_i)
        |=> (burst_q && seg_idx_q == '0 && seg_cnt_q == '0)); // R7

    AST_MODE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && mode_in != mode_q)
        |=> (seg_cnt_q == '0 && seg_idx_q == '0 && !burst_q)); // R10

endmodule

// File: rtl/buzz_tone_gen.sv
// Module: top of the buzzer tone generator; gates the tone with the envelope.
// Assumes all inputs are synchronous to clk; output is low when silent.
module buzz_tone_gen #(
    parameter int TICK_DIV  = 1000,
    parameter int SEG_TICKS = 3000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_i,
    input  logic [1:0] mode_i,
    input  logic [2:0] freq_sel_i,
    input  logic       trig_i,
    output logic       buzz_o
);

    logic tick;
    logic phase;
    logic gate;

    buzz_tick_div #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    buzz_tone_osc u_osc (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick),
        .en_i       (en_i),
        .freq_sel_i (freq_sel_i),
        .phase_o    (phase)
    );

    buzz_envelope #(.SEG_TICKS(SEG_TICKS)) u_env (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (tick),
        .en_i   (en_i),
        .mode_i (mode_i),
        .trig_i (trig_i),
        .gate_o (gate)
    );

    assign buzz_o = phase & gate;

    AST_OUT_LOW_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !buzz_o); // R5

    AST_OUT_LOW_IN_RESET: assert property (@(posedge clk)
        !rst_n |=> !buzz_o); // R1

endmodule

// File: tb/buzz_tone_gen_bench.sv
module buzz_tone_gen_bench;

    localparam int TDIV = 3;
    localparam int SEG  = 100;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       en;
    logic [1:0] mode;
    logic [2:0] freq;
    logic       trig;
    logic       buzz;

    int    checks = 0;
    int    errors = 0;
    string phase_tag = "R1";
    bit    done = 1'b0;

    // Model state
    int edge_n, tone_t, env_t;
    bit burst_m, exp_out;
    logic [2:0] f_prev;
    logic [1:0] m_prev;

    always #5 clk = ~clk;

    buzz_tone_gen #(.TICK_DIV(TDIV), .SEG_TICKS(SEG)) u_buzz_tone_gen (
        .clk(clk), .rst_n(rst_n), .en_i(en), .mode_i(mode),
        .freq_sel_i(freq), .trig_i(trig), .buzz_o(buzz)
    );

    // R3: half period in ticks from pitch in Hz at a 60 kHz tick
    function automatic int half_of(input logic [2:0] s);
        int hz;
        case (s)
            3'd0: hz = 625;  3'd1: hz = 750;  3'd2: hz = 1000; 3'd3: hz = 1250;
            3'd4: hz = 1500; 3'd5: hz = 2000; 3'd6: hz = 2500; default: hz = 3000;
        endcase
        return 30000 / hz;
    endfunction

    function automatic bit gate_of(input logic [1:0] m, input int et, input bit b);
        int seg;
        seg = (et / SEG) % 20;
        case (m)
            2'd0: return 1'b1;
            2'd1: return b;
            2'd2: return (seg % 2) == 0;
            default: return (seg < 10) && ((seg % 2) == 0);
        endcase
    endfunction

    function automatic string mode_tag(input bit e, input logic [1:0] m);
        if (!e) return "R5";
        case (m)
            2'd0: return "R6";
            2'd1: return "R7";
            2'd2: return "R8";
            default: return "R9";
        endcase
    endfunction

    // Reference model, evaluated on elapsed ticks
    always @(posedge clk) begin
        bit tick;
        if (!rst_n) begin
            edge_n = 0; tone_t = 0; env_t = 0; burst_m = 0;
            f_prev = '0; m_prev = '0; exp_out = 0;
        end else begin
            tick = (edge_n % TDIV) == TDIV - 1;  // R2
            edge_n++;
            if (!en || freq != f_prev) tone_t = 0;
            else if (tick) tone_t++;
            f_prev = freq;
            if (!en || mode != m_prev) begin
                env_t = 0; burst_m = 0;
            end else if (mode == 2'd1 && trig) begin
                env_t = 0; burst_m = 1;
            end else if (tick) begin
                env_t++;
                if (env_t >= 2 * SEG) burst_m = 0;
            end
            m_prev = mode;
            exp_out = (((tone_t / half_of(freq)) % 2) == 1) && gate_of(mode, env_t, burst_m);
        end
    end

    // Per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (buzz !== exp_out) begin
                errors++;
                $display("FAIL %s (%s) t=%0t buzz=%b expected=%b",
                         mode_tag(en, mode), phase_tag, $time, buzz, exp_out);
            end
        end
    end

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_trig;
        @(negedge clk) trig = 1'b1;
        @(negedge clk) trig = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd7731));
        rst_n = 1'b0; en = 1'b0; mode = 2'd0; freq = 3'd0; trig = 1'b0;
        run(4);
        checks++;
        if (buzz !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset buzz=%b expected=0", buzz);
        end
        rst_n = 1'b1;
        run(10);

        phase_tag = "R3";
        en = 1'b1;
        for (int f = 0; f < 8; f++) begin
            freq = 3'(f);
            run(320);
        end

        phase_tag = "R4";
        freq = 3'd7; run(50);
        freq = 3'd2; run(220);

        phase_tag = "R2";
        freq = 3'd7; run(200);

        phase_tag = "R5";
        en = 1'b0; trig = 1'b1; run(40); trig = 1'b0; run(20);
        en = 1'b1;

        phase_tag = "R7";
        mode = 2'd1; freq = 3'd6; run(100);
        pulse_trig(); run(700);
        pulse_trig(); run(300);
        pulse_trig(); run(700);

        phase_tag = "R11";
        mode = 2'd2; run(100);
        pulse_trig(); run(150); pulse_trig(); run(450);

        phase_tag = "R8";
        mode = 2'd3; run(2); mode = 2'd2; run(900);

        phase_tag = "R9";
        mode = 2'd3; run(6600);

        phase_tag = "R10";
        run(150); mode = 2'd2; run(150); mode = 2'd3; run(3200);
        mode = 2'd1; pulse_trig(); run(100); mode = 2'd0; run(200);

        phase_tag = "random";
        for (int i = 0; i < 40; i++) begin
            en   = ($urandom % 8) != 0;
            mode = 2'($urandom % 4);
            freq = 3'($urandom % 8);
            for (int k = 0; k < 4; k++) begin
                if (($urandom % 3) == 0) pulse_trig();
                run(20 + int'($urandom % 150));
            end
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule